// File: doc/BRIEF.md
# Fractional bit-rate tick generator

This block paces a serial transmitter. A 16-bit increment is added every peripheral clock into a 20-bit phase accumulator, and each carry out of the accumulator's top bit gives a one-cycle bit tick. The tick rate is therefore increment × f_clk / 2^20. Because the increment is not restricted to integer divisions of the clock, rates between those divisions are also reachable. A second counter counts ticks in groups of ten: one start bit, eight data bits and one stop bit. On the tenth tick of each group it raises a character-done strobe, which a transmit queue uses to release its next byte.

The increment comes from the upper half of a 32-bit control word. A write whose upper half is nonzero loads the new increment and restarts both the accumulator and the character counter. A write whose upper half is zero leaves everything as it was. After reset the increment holds the value for 230400 bit/s at the clock given by a parameter.

Top module: `nco_bitrate_gen`

## Requirements
- R1: After reset `rate_o` equals floor(DEF_BAUD × 2^20 / CLK_HZ), which is 4831 for the defaults, and the first tick appears on the clock edge where the accumulated sum first reaches 2^20.
- R2: Each clock edge adds the increment into a 20-bit accumulator (modulo 2^20). `bit_tick_o` is high for the one cycle that follows each edge on which the sum reaches or exceeds 2^20.
- R3: `bit_tick_o` is never high in two consecutive cycles.
- R4: `char_done_o` is high together with every tenth `bit_tick_o`, counted from reset or from the last accepted load.
- R5: A control write with bits 31:16 nonzero sets `rate_o` to those bits in the next cycle. It also clears the accumulator, the pending tick and the character count, so ticks begin again after ceil(2^20 / increment) cycles.
- R6: A control write with bits 31:16 equal to zero is ignored: `rate_o`, the tick phase and the character count continue unchanged.
- R7: Bits 15:0 of a control write have no effect on `rate_o` or on the tick timing.
- R8: `char_done_o` is never high while `bit_tick_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word; bits 31:16 carry the increment |
| bit_tick_o | output | 1 | One-cycle pulse per bit period |
| char_done_o | output | 1 | One-cycle pulse on every tenth bit tick |
| rate_o | output | 16 | Increment currently in use |

## Verification
A corrupted accumulator changes the spacing of the bit ticks. At the expected tick position the output then disagrees with a model that counts phase, which happens within one bit period, at most 2^20 / increment cycles. A character counter that is off by one moves `char_done_o` to the wrong tick inside the first ten ticks. A load that fails to clear state shows up as an early first tick after the write. Zero-field and low-half writes are checked by watching `rate_o` and whether the tick phase continues unbroken.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // increment for a wanted bit rate: floor(baud * 2^acc_w / clk_hz)
  function automatic logic [63:0] calc_inc(input longint clk_hz, input longint baud,
                                           input int acc_w);
    return 64'((baud << acc_w) / clk_hz);
  endfunction
endpackage

// File: rtl/nco_rate_reg.sv
module nco_rate_reg #(
  parameter int              NCO_W   = 16,
  parameter logic [NCO_W-1:0] DEF_INC = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [NCO_W-1:0] field_i,
  output logic             load_o,
  output logic [NCO_W-1:0] inc_o
);
  logic [NCO_W-1:0] inc_q;

  assign load_o = we_i && (field_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inc_q <= DEF_INC;
    else if (load_o) inc_q <= field_i;
  end

  assign inc_o = inc_q;
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int NCO_W = 16,
  parameter int ACC_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [NCO_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             tick_q;

  assign sum = {1'b0, acc_q} + (ACC_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      tick_q <= sum[ACC_W];
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/nco_char_cnt.sv
module nco_char_cnt #(
  parameter int CHAR_BITS = 10,
  localparam int CNT_W    = $clog2(CHAR_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_BITS - 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign done_o = tick_i && (cnt_q == LAST);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/nco_bitrate_gen.sv
module nco_bitrate_gen #(
  parameter longint CLK_HZ    = 50_000_000,
  parameter longint DEF_BAUD  = 230_400,
  parameter int     NCO_W     = 16,
  parameter int     ACC_W     = 20,
  parameter int     CHAR_BITS = 10,
  localparam int    CNT_W     = $clog2(CHAR_BITS),
  localparam logic [NCO_W-1:0] DEF_INC =
    NCO_W'(nco_pkg::calc_inc(CLK_HZ, DEF_BAUD, ACC_W))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [31:0]      ctrl_wdata_i,
  output logic             bit_tick_o,
  output logic             char_done_o,
  output logic [NCO_W-1:0] rate_o
);
  logic             load;
  logic [NCO_W-1:0] inc;
  logic             tick;
  logic [CNT_W-1:0] char_cnt;

  nco_rate_reg #(.NCO_W(NCO_W), .DEF_INC(DEF_INC)) u_rate (
    .clk_i, .rst_ni,
    .we_i   (ctrl_we_i),
    .field_i(ctrl_wdata_i[16 +: NCO_W]),
    .load_o (load),
    .inc_o  (inc)
  );

  nco_phase_acc #(.NCO_W(NCO_W), .ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni,
    .clr_i (load),
    .inc_i (inc),
    .tick_o(tick)
  );

  nco_char_cnt #(.CHAR_BITS(CHAR_BITS)) u_char (
    .clk_i, .rst_ni,
    .clr_i (load),
    .tick_i(tick),
    .done_o(char_done_o),
    .cnt_o (char_cnt)
  );

  assign bit_tick_o = tick;
  assign rate_o     = inc;
endmodule

// File: rtl/nco_bitrate_gen_chk.sv
module nco_bitrate_gen_chk #(
  parameter int NCO_W     = 16,
  parameter int CHAR_BITS = 10,
  localparam int CNT_W    = $clog2(CHAR_BITS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [31:0]      ctrl_wdata_i,
  input logic             bit_tick_o,
  input logic             char_done_o,
  input logic [NCO_W-1:0] rate_o,
  input logic [CNT_W-1:0] char_cnt
);
  logic acc_load;
  assign acc_load = ctrl_we_i && (ctrl_wdata_i[16 +: NCO_W] != '0);

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |=> !bit_tick_o); // R3
  AST_DONE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done_o |-> bit_tick_o); // R8
  AST_RATE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_load |=> rate_o == $past(ctrl_wdata_i[16 +: NCO_W])); // R5
  AST_LOAD_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_load |=> !bit_tick_o && char_cnt == '0); // R5
  AST_RATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_load |=> $stable(rate_o)); // R6
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_cnt < CNT_W'(CHAR_BITS)); // R4
endmodule

bind nco_bitrate_gen nco_bitrate_gen_chk #(.NCO_W(NCO_W), .CHAR_BITS(CHAR_BITS)) u_chk (
  .clk_i, .rst_ni, .ctrl_we_i, .ctrl_wdata_i,
  .bit_tick_o, .char_done_o, .rate_o, .char_cnt
);

// File: tb/nco_bitrate_gen_tb.sv
module nco_bitrate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam longint ACC_MOD = 1048576;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [31:0] ctrl_wdata_i = '0;
  logic        bit_tick_o, char_done_o;
  logic [15:0] rate_o;

  nco_bitrate_gen u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  // reference model state
  longint m_acc, m_inc;
  int     m_cnt;
  bit     m_tick;
  int     tick_total, done_total;
  bit     prev_tick;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive inputs, advance model at edge, compare at falling edge
  task automatic step(input bit we, input logic [31:0] wd);
    ctrl_we_i    = we;
    ctrl_wdata_i = wd;
    @(posedge clk_i);
    if (we && wd[31:16] != 0) begin
      m_inc = wd[31:16]; m_acc = 0; m_tick = 0; m_cnt = 0;
    end else begin
      if (m_tick) m_cnt = (m_cnt + 1) % 10;
      m_acc  = m_acc + m_inc;
      m_tick = (m_acc >= ACC_MOD);
      m_acc  = m_acc % ACC_MOD;
    end
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
    chk(bit_tick_o == m_tick, "R2 tick", bit_tick_o, m_tick);
    chk(char_done_o == (m_tick && m_cnt == 9), "R4 char_done", char_done_o, m_tick && m_cnt == 9);
    chk(rate_o == 16'(m_inc), "R5 rate", rate_o, m_inc);
    chk(!(prev_tick && bit_tick_o), "R3 consecutive ticks", bit_tick_o, 0);
    chk(!(char_done_o && !bit_tick_o), "R8 done without tick", char_done_o, bit_tick_o);
    prev_tick = bit_tick_o;
    tick_total += int'(bit_tick_o);
    done_total += int'(char_done_o);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    longint def_inc;
    int first;
    def_inc = (longint'(230400) * ACC_MOD) / 50_000_000;
    m_inc = def_inc; m_acc = 0; m_tick = 0; m_cnt = 0;
    tick_total = 0; done_total = 0; prev_tick = 0;
    repeat (3) @(negedge clk_i);
    chk(rate_o == 16'd4831, "R1 reset rate", rate_o, 4831);
    chk(bit_tick_o == 0 && char_done_o == 0, "R1 reset outputs", bit_tick_o, 0);
    rst_ni = 1'b1;

    // R1: default rate, about 217 cycles per bit, >= 10 ticks
    run(2300);
    chk(tick_total == 2300 * def_inc / ACC_MOD, "R1 default tick count", tick_total, 2300 * def_inc / ACC_MOD);
    chk(done_total == 1, "R4 default done count", done_total, 1);

    // R5/R7: load half rate with junk in low half
    step(1'b1, 32'h8000_1234);
    chk(rate_o == 16'h8000, "R7 low half ignored", rate_o, 16'h8000);
    tick_total = 0; done_total = 0; first = -1;
    for (int i = 1; i <= 320; i++) begin
      step(1'b0, '0);
      if (bit_tick_o && first < 0) first = i;
    end
    chk(first == 32, "R5 first tick after load", first, 32);
    chk(tick_total == 10, "R2 half-rate ticks", tick_total, 10);
    chk(done_total == 1, "R4 one char per ten ticks", done_total, 1);

    // R6: zero-field write ignored mid-character
    run(45);
    step(1'b1, 32'h0000_FFFF);
    chk(rate_o == 16'h8000, "R6 zero field ignored", rate_o, 16'h8000);
    run(200);

    // R3: maximum increment, fractional rate
    step(1'b1, 32'hFFFF_0000);
    tick_total = 0; done_total = 0;
    run(1700);
    chk(tick_total == 1700 * 65535 / ACC_MOD, "R2 max rate ticks", tick_total, 1700 * 65535 / ACC_MOD);
    chk(done_total == tick_total / 10, "R4 max rate chars", done_total, tick_total / 10);

    // R5: reload mid-character restarts count
    run(77);
    step(1'b1, 32'h3001_0000);
    run(1200);

    // R5/R7: same field, different low half, still restarts phase
    step(1'b1, 32'h3001_ABCD);
    chk(rate_o == 16'h3001, "R7 low half ignored again", rate_o, 16'h3001);
    run(400);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule